// File: doc/BRIEF.md
# Per-Pin Event Detector with Interrupt, DMA and Trigger Outputs

This block watches the already-synchronized levels of the pins of one port and turns pin activity into events. Every pin carries its own 4-bit condition code. The code decides whether that pin's rising edges, falling edges, both edges or a held level are of interest. It also decides where an event goes: to a DMA request, to the interrupt line, only to the status flag, or straight out as a per-pin trigger level.

Detected events latch into a status flag register, one bit per pin, with bit n belonging to pin n. Software clears a flag by writing a 1 to that bit. A DMA-done strobe clears the flags of pins that are in DMA modes. A pin in a level mode whose level is still active sets its flag again at once. The block reduces the flags to one interrupt line and one DMA request line, masking each by the pin's current mode.

Top module: `pin_event_detector`

## Requirements
- R1: While `rst` is high, `flags`, `irq` and `dma_req` are 0. In the first clock after reset is released no edge is detected, even if a pin is already high; edges are found only by comparing a pin with its value sampled one clock earlier.
- R2: Codes 1, 2 and 3 set the pin's flag on a rising edge, a falling edge or either edge. Such a flag drives `dma_req` and not `irq`.
- R3: Codes 5, 6 and 7 set the pin's flag on a rising, falling or either edge. Such a flag drives neither `irq` nor `dma_req`.
- R4: Codes 9, 10 and 11 set the pin's flag on a rising, falling or either edge, and the flag drives `irq`.
- R5: Code 8 sets the flag in every clock in which the pin is 0. Code 12 does the same while the pin is 1. A clear of such a flag while the level persists leaves it set.
- R6: With code 13, `trig_out[n]` equals the pin level. With code 14 it equals the inverted pin level. With any other code it is 0. Codes 13 and 14 never set a flag.
- R7: Codes 0, 4 and 15 never set a flag.
- R8: When `flag_wr_en` is high, each 1 bit in `flag_wr_data` clears that flag at the next clock; 0 bits leave their flags unchanged.
- R9: A `dma_done` pulse clears at the next clock the flags of all pins whose code is 1, 2 or 3, and leaves all other flags alone.
- R10: If an event and a clear (by write or by `dma_done`) hit the same flag in the same clock, the flag stays set.
- R11: Flag bit n belongs to pin n: events on pins 0 and 16 give `flags` = 0x00010001.
- R12: `irq` is the OR of flags whose pins have codes 8 to 12. `dma_req` is the OR of flags whose pins have codes 1 to 3. Both use the current codes and flag register without extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | 32 | Synchronized pin levels |
| cond_code | input | 128 | Condition code per pin, pin n in bits [4n+3:4n] |
| flag_wr_en | input | 1 | Write strobe for the flag register |
| flag_wr_data | input | 32 | Write-one-to-clear data for the flags |
| dma_done | input | 1 | DMA transfer complete strobe |
| flags | output | 32 | Status flag register |
| irq | output | 1 | Combined interrupt request |
| dma_req | output | 1 | Combined DMA request |
| trig_out | output | 32 | Per-pin trigger outputs |

## Verification
A pin change, clear write or `dma_done` applied before a rising edge shows up in `flags` right after that edge. `irq` and `dma_req` follow in the same cycle, because they are plain reductions of the flag register. `trig_out` follows pin levels and codes combinationally, so the bench checks it a short delay after it drives the inputs, before the clock edge. The bench drives inputs on the falling edge, lets one rising edge pass, and compares flags and request lines at the next falling edge against a cycle model. It repeats this while rotating every condition code over every pin.

// File: rtl/pin_evt_pkg.sv
`timescale 1ns/1ps
package pin_evt_pkg;

    localparam int CODE_W = 4;

    typedef enum logic [CODE_W-1:0] {
        COND_OFF  = 4'd0,
        DMA_RISE  = 4'd1,
        DMA_FALL  = 4'd2,
        DMA_ANY   = 4'd3,
        COND_RSV4 = 4'd4,
        FLG_RISE  = 4'd5,
        FLG_FALL  = 4'd6,
        FLG_ANY   = 4'd7,
        IRQ_LOW   = 4'd8,
        IRQ_RISE  = 4'd9,
        IRQ_FALL  = 4'd10,
        IRQ_ANY   = 4'd11,
        IRQ_HIGH  = 4'd12,
        TRG_HIGH  = 4'd13,
        TRG_LOW   = 4'd14,
        COND_RSVF = 4'd15
    } cond_e;

    typedef struct packed {
        logic hit;
        logic to_dma;
        logic to_irq;
        logic trig;
    } pin_res_t;

    // low two code bits select the edge kind: 1 rise, 2 fall, 3 both
    function automatic logic edge_match(logic [1:0] sel, logic rise, logic fall);
        return (sel[0] & rise) | (sel[1] & fall);
    endfunction

    function automatic pin_res_t eval_pin(logic [CODE_W-1:0] code, logic lvl,
                                          logic rise, logic fall);
        pin_res_t res;
        res = '0;
        case (code)
            DMA_RISE, DMA_FALL, DMA_ANY: begin
                res.hit    = edge_match(code[1:0], rise, fall);
                res.to_dma = 1'b1;
            end
            FLG_RISE, FLG_FALL, FLG_ANY: begin
                res.hit = edge_match(code[1:0], rise, fall);
            end
            IRQ_RISE, IRQ_FALL, IRQ_ANY: begin
                res.hit    = edge_match(code[1:0], rise, fall);
                res.to_irq = 1'b1;
            end
            IRQ_LOW: begin
                res.hit    = ~lvl;
                res.to_irq = 1'b1;
            end
            IRQ_HIGH: begin
                res.hit    = lvl;
                res.to_irq = 1'b1;
            end
            TRG_HIGH: res.trig = lvl;
            TRG_LOW:  res.trig = ~lvl;
            default:  res = '0;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/pin_evt_sampler.sv
`timescale 1ns/1ps
module pin_evt_sampler #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] lvl,
    output logic [NUM_PINS-1:0] rise,
    output logic [NUM_PINS-1:0] fall
);
    logic [NUM_PINS-1:0] prev_q;
    logic                armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            armed_q <= 1'b1;
        end
    end

    // no edge until a real previous sample exists
    always_comb begin
        rise = armed_q ? (lvl & ~prev_q) : '0;
        fall = armed_q ? (~lvl & prev_q) : '0;
    end
endmodule

// File: rtl/pin_evt_decode.sv
`timescale 1ns/1ps
module pin_evt_decode
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0]        lvl,
    input  logic [NUM_PINS-1:0]        rise,
    input  logic [NUM_PINS-1:0]        fall,
    input  logic [NUM_PINS*CODE_W-1:0] codes,
    output logic [NUM_PINS-1:0]        hit,
    output logic [NUM_PINS-1:0]        dma_mask,
    output logic [NUM_PINS-1:0]        irq_mask,
    output logic [NUM_PINS-1:0]        trig
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pin_res_t res;
        always_comb begin
            res         = eval_pin(codes[i*CODE_W +: CODE_W], lvl[i], rise[i], fall[i]);
            hit[i]      = res.hit;
            dma_mask[i] = res.to_dma;
            irq_mask[i] = res.to_irq;
            trig[i]     = res.trig;
        end
    end
endmodule

// File: rtl/pin_evt_flags.sv
`timescale 1ns/1ps
module pin_evt_flags #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] hit,
    input  logic                wr_en,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic                dma_done,
    input  logic [NUM_PINS-1:0] dma_mask,
    output logic [NUM_PINS-1:0] flags
);
    logic [NUM_PINS-1:0] clr;

    always_comb begin
        clr = (wr_en ? wr_data : '0) | (dma_done ? dma_mask : '0);
    end

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr) | hit;
    end
endmodule

// File: rtl/pin_event_detector.sv
`timescale 1ns/1ps
module pin_event_detector
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_PINS-1:0]         pin_lvl,
    input  logic [NUM_PINS*CODE_W-1:0]  cond_code,
    input  logic                        flag_wr_en,
    input  logic [NUM_PINS-1:0]         flag_wr_data,
    input  logic                        dma_done,
    output logic [NUM_PINS-1:0]         flags,
    output logic                        irq,
    output logic                        dma_req,
    output logic [NUM_PINS-1:0]         trig_out
);
    logic [NUM_PINS-1:0] rise, fall, hit, dma_mask, irq_mask;

    pin_evt_sampler #(.NUM_PINS(NUM_PINS)) u_sampler (
        .clk (clk), .rst (rst), .lvl (pin_lvl), .rise (rise), .fall (fall)
    );

    pin_evt_decode #(.NUM_PINS(NUM_PINS)) u_decode (
        .lvl (pin_lvl), .rise (rise), .fall (fall), .codes (cond_code),
        .hit (hit), .dma_mask (dma_mask), .irq_mask (irq_mask), .trig (trig_out)
    );

    pin_evt_flags #(.NUM_PINS(NUM_PINS)) u_flags (
        .clk (clk), .rst (rst), .hit (hit), .wr_en (flag_wr_en),
        .wr_data (flag_wr_data), .dma_done (dma_done), .dma_mask (dma_mask),
        .flags (flags)
    );

    always_comb begin
        irq     = |(flags & irq_mask);
        dma_req = |(flags & dma_mask);
    end
endmodule

// File: rtl/pin_event_detector_chk.sv
`timescale 1ns/1ps
module pin_event_detector_chk
    import pin_evt_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic [NUM_PINS-1:0]         pin_lvl,
    input logic [NUM_PINS*CODE_W-1:0]  cond_code,
    input logic                        flag_wr_en,
    input logic [NUM_PINS-1:0]         flag_wr_data,
    input logic                        dma_done,
    input logic [NUM_PINS-1:0]         flags,
    input logic                        irq,
    input logic                        dma_req,
    input logic [NUM_PINS-1:0]         trig_out
);
    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (flags == '0 && !irq && !dma_req));

    p_irq_src_r12: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flags != '0));

    p_dma_src_r12: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (flags != '0));

    p_wr_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (flag_wr_en && !dma_done) |=>
        ((flags & $past(flags & ~flag_wr_data)) == $past(flags & ~flag_wr_data)));

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic [CODE_W-1:0] c;
        assign c = cond_code[i*CODE_W +: CODE_W];

        p_trig_r6: assert property (@(posedge clk) disable iff (rst)
            trig_out[i] == ((c == TRG_HIGH) ? pin_lvl[i] :
                            (c == TRG_LOW)  ? ~pin_lvl[i] : 1'b0));

        p_off_no_set_r7: assert property (@(posedge clk) disable iff (rst)
            ((c == COND_OFF || c == COND_RSV4 || c == COND_RSVF ||
              c == TRG_HIGH || c == TRG_LOW) && !flags[i] && !rst) |=> !flags[i]);
    end
endmodule

bind pin_event_detector pin_event_detector_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk (clk), .rst (rst), .pin_lvl (pin_lvl), .cond_code (cond_code),
    .flag_wr_en (flag_wr_en), .flag_wr_data (flag_wr_data), .dma_done (dma_done),
    .flags (flags), .irq (irq), .dma_req (dma_req), .trig_out (trig_out)
);

// File: tb/pin_event_detector_bench.sv
`timescale 1ns/1ps
module pin_event_detector_bench;
    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  pin_lvl = '0;
    logic [N*4-1:0] cond_code = '0;
    logic          flag_wr_en = 1'b0;
    logic [N-1:0]  flag_wr_data = '0;
    logic          dma_done = 1'b0;
    logic [N-1:0]  flags;
    logic          irq, dma_req;
    logic [N-1:0]  trig_out;

    pin_event_detector #(.NUM_PINS(N)) u_pin_event_detector (
        .clk (clk), .rst (rst), .pin_lvl (pin_lvl), .cond_code (cond_code),
        .flag_wr_en (flag_wr_en), .flag_wr_data (flag_wr_data), .dma_done (dma_done),
        .flags (flags), .irq (irq), .dma_req (dma_req), .trig_out (trig_out)
    );

    always #2.5 clk = ~clk;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;

    int          code_of [N];
    logic [N-1:0] m_flags = '0;
    logic [N-1:0] m_prev  = '0;
    bit          m_armed = 0;
    logic [31:0] seed = 32'h1357_9bdf;

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    function automatic bit is_dma(int c);  return c >= 1 && c <= 3;  endfunction
    function automatic bit is_irq(int c);  return c >= 8 && c <= 12; endfunction
    function automatic bit is_flg(int c);  return c >= 5 && c <= 7;  endfunction
    function automatic bit is_off(int c);
        return c == 0 || c == 4 || c >= 13;
    endfunction

    function automatic bit exp_hit(int c, bit l, bit r, bit f);
        int k;
        k = c % 4;
        if (is_dma(c) || is_flg(c) || (c >= 9 && c <= 11))
            return (k == 1 && r) || (k == 2 && f) || (k == 3 && (r || f));
        if (c == 8)  return !l;
        if (c == 12) return l;
        return 0;
    endfunction

    task automatic load_codes();
        for (int i = 0; i < N; i++) cond_code[i*4 +: 4] = 4'(code_of[i]);
    endtask

    function automatic logic [N-1:0] class_mask(int which);
        logic [N-1:0] m;
        m = '0;
        for (int i = 0; i < N; i++)
            case (which)
                0: m[i] = is_dma(code_of[i]);
                1: m[i] = is_flg(code_of[i]);
                2: m[i] = code_of[i] >= 9 && code_of[i] <= 11;
                3: m[i] = code_of[i] == 8 || code_of[i] == 12;
                default: m[i] = is_off(code_of[i]);
            endcase
        return m;
    endfunction

    // called at a falling edge; returns at the next falling edge
    task automatic step(logic [N-1:0] pins, bit wen, logic [N-1:0] wdat, bit dd);
        logic [N-1:0] ev, clr, exp_trig;
        pin_lvl = pins; flag_wr_en = wen; flag_wr_data = wdat; dma_done = dd;
        ev = '0; clr = '0; exp_trig = '0;
        for (int i = 0; i < N; i++) begin
            bit r, f;
            r = m_armed && pins[i] && !m_prev[i];
            f = m_armed && !pins[i] && m_prev[i];
            ev[i] = exp_hit(code_of[i], pins[i], r, f);
            clr[i] = (wen && wdat[i]) || (dd && is_dma(code_of[i]));
            exp_trig[i] = (code_of[i] == 13) ? pins[i] :
                          (code_of[i] == 14) ? !pins[i] : 1'b0;
        end
        #1;
        chk("R6 trigger outputs", trig_out, exp_trig);
        m_flags = (m_flags & ~clr) | ev;
        m_prev  = pins;
        m_armed = 1;
        @(posedge clk);
        @(negedge clk);
        flag_wr_en = 1'b0; dma_done = 1'b0;
        chk("R2 dma-mode flags",   flags & class_mask(0), m_flags & class_mask(0));
        chk("R3 flag-only flags",  flags & class_mask(1), m_flags & class_mask(1));
        chk("R4 edge irq flags",   flags & class_mask(2), m_flags & class_mask(2));
        chk("R5 level irq flags",  flags & class_mask(3), m_flags & class_mask(3));
        chk("R7 disabled flags",   flags & class_mask(4), m_flags & class_mask(4));
        chk("R12 irq line", 32'(irq),
            32'(|(m_flags & (class_mask(2) | class_mask(3)))));
        chk("R12 dma line", 32'(dma_req), 32'(|(m_flags & class_mask(0))));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) code_of[i] = 0;
        code_of[0] = 1;
        load_codes();
        pin_lvl = 32'h1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 reset flags", flags, 0);
        chk("R1 reset irq", 32'(irq), 0);
        chk("R1 reset dma", 32'(dma_req), 0);
        rst = 1'b0;
        step(32'h1, 0, 0, 0);
        chk("R1 no edge in first cycle", flags, 0);

        // R11 bit mapping with rising-edge interrupts
        for (int i = 0; i < N; i++) code_of[i] = 9;
        load_codes();
        step(32'h0, 0, 0, 0);
        step(32'h0001_0001, 0, 0, 0);
        chk("R11 pins 0 and 16", flags, 32'h0001_0001);
        chk("R4 irq raised", 32'(irq), 1);

        // R8 write zero keeps, write one clears
        step(32'h0001_0001, 1, 32'h0, 0);
        chk("R8 zero write no effect", flags, 32'h0001_0001);
        step(32'h0001_0001, 1, 32'h1, 0);
        chk("R8 one write clears", flags, 32'h0001_0000);

        // R10/R5 level-high clear collision
        code_of[16] = 12;
        load_codes();
        step(32'h0001_0001, 1, 32'h0001_0000, 0);
        chk("R10 event beats clear", flags, 32'h0001_0000);
        step(32'h0000_0001, 1, 32'h0001_0000, 0);
        chk("R5 level gone then clear", flags, 32'h0);

        // R9 DMA completion clears only DMA-mode flags
        for (int i = 0; i < N; i++) code_of[i] = 0;
        code_of[3] = 2; code_of[4] = 6;
        load_codes();
        step(32'h18, 0, 0, 0);
        step(32'h00, 0, 0, 0);
        chk("R9 both fall flags set", flags, 32'h18);
        chk("R2 dma request", 32'(dma_req), 1);
        chk("R3 no irq from flag-only", 32'(irq), 0);
        step(32'h00, 0, 0, 1);
        chk("R9 dma done clears dma pin", flags, 32'h10);
        chk("R9 dma request drops", 32'(dma_req), 0);
        step(32'h00, 1, 32'h10, 0);

        // sweep every code over every pin with random traffic
        for (int rot = 0; rot < 16; rot++) begin
            for (int i = 0; i < N; i++) code_of[i] = (i + rot) % 16;
            load_codes();
            for (int s = 0; s < 150; s++) begin
                logic [31:0] a, b, c;
                a = nxt(); b = nxt(); c = nxt();
                step(pin_lvl ^ (a & b), c[1:0] == 2'd0, c, c[7:5] == 3'd0);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule